// File: doc/BRIEF.md
# Label Storage Read/Write Engine

This block carries out read and write commands against a small byte-addressed label store held inside it. A mailbox front end, which is not part of this block, loads a command payload into the block's payload buffer through a byte-wide host port. It then pulses a command strobe, with a flag that selects read or write and the payload length in bytes. The engine checks the request against the store size before any byte moves. It then moves one byte per clock between the payload buffer and the store. When it finishes, it reports a return code and an output length together with a one-cycle completion pulse.

A read takes an 8-byte header: a 32-bit byte offset in payload bytes 0..3 and a 32-bit byte count in payload bytes 4..7, both little-endian. The data read from the store is placed at the start of the payload buffer, where the host port can read it back. A write takes a header of the same 8-byte size: the offset in bytes 0..3 and a reserved word in bytes 4..7 that the engine ignores. The data follows from byte 8. The number of data bytes is the payload length minus 8. Every bounds sum is formed at 33 bits, so an offset close to 2^32 cannot wrap round and slip past the check.

Top module: `lsa_engine`

## Requirements
- R1: After reset, busy, done, ret_code and out_len are all 0.
- R2: A read whose offset plus count is at most AREA_BYTES, and whose count is at most PB_BYTES, copies store bytes offset..offset+count-1 into payload bytes 0..count-1. It returns ret_code 0x00 and out_len equal to the count. A count of 0 succeeds and moves nothing.
- R3: A read is rejected with ret_code 0x02 (invalid input) and out_len 0 when offset plus count, summed at 33 bits without wrap, exceeds AREA_BYTES, or when the count exceeds PB_BYTES. No payload byte is changed.
- R4: A write with payload length L of 8 or more that passes the bounds check copies payload bytes 8..L-1 into the store starting at the offset. It returns ret_code 0x00 and out_len 0. The reserved word has no effect, and L of exactly 8 succeeds with nothing written.
- R5: A write with payload length 0 returns ret_code 0x00 and out_len 0 and leaves the store unchanged.
- R6: A write is rejected with ret_code 0x02 and out_len 0, with the store unchanged, when offset plus L (33-bit sum) exceeds AREA_BYTES+8, when L is 1..7, or when L exceeds PB_BYTES.
- R7: busy rises in the cycle after an accepted strobe and stays high for N+2 cycles, where N is the number of bytes moved (0 for rejected or empty commands). done is a one-cycle pulse in the first cycle in which busy is low again. ret_code and out_len change only together with done and hold their values until the next completion.
- R8: A command strobe while busy is ignored, and so is a host write into the payload buffer while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy is low |
| cmd_is_write | input | 1 | 1 selects write, 0 selects read |
| cmd_len | input | 16 | Payload length in bytes (used by writes) |
| host_we | input | 1 | Host write enable into the payload buffer |
| host_addr | input | $clog2(PB_BYTES) | Host byte address in the payload buffer |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Payload buffer byte at host_addr |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ret_code | output | 8 | Return code: 0x00 success, 0x02 invalid input |
| out_len | output | 16 | Output payload length of the last command |

## Verification
The assertions assume that the host leaves the payload buffer header alone between the strobe and the accept edge. They also assume the command inputs are driven with known values whenever the strobe is high. The bench meets both by loading every header before it pulses the strobe, and by driving all inputs only on the falling clock edge. The bound checks on the store address depend on the verdict being computed in the cycle before the first byte moves. The bench makes the engine compute that verdict on offsets right at the store edge, one byte past it, and close to 2^32, so the overflow path is exercised in both directions. The only input the bench drives during a busy window is the deliberate strobe and host write that test R8.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam logic [7:0] RC_OK        = 8'h00;
  localparam logic [7:0] RC_BAD_INPUT = 8'h02;
  localparam int unsigned HDR_BYTES   = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHK,
    ST_XFER,
    ST_FIN
  } lsa_state_e;

  // Read window check: 33-bit end address so a large offset cannot wrap.
  function automatic logic rd_in_bounds(input logic [31:0] off,
                                        input logic [31:0] cnt,
                                        input int unsigned area,
                                        input int unsigned pbuf);
    logic [32:0] last;
    last = {1'b0, off} + {1'b0, cnt};
    return (last <= 33'(area)) && ({1'b0, cnt} <= 33'(pbuf));
  endfunction

  // Write window check: header bytes are part of the length, so the
  // limit is widened by the header size.
  function automatic logic wr_in_bounds(input logic [31:0] off,
                                        input logic [15:0] plen,
                                        input int unsigned area,
                                        input int unsigned pbuf);
    logic [32:0] last;
    last = {1'b0, off} + 33'(plen);
    return (plen >= 16'(HDR_BYTES)) && (17'(plen) <= 17'(pbuf))
           && (last <= 33'(area) + 33'(HDR_BYTES));
  endfunction

endpackage

// File: rtl/lsa_area.sv
module lsa_area #(
  parameter int AREA_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(AREA_BYTES)-1:0] addr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata
);
  logic [7:0] mem [AREA_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < AREA_BYTES; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/lsa_pbuf.sv
module lsa_pbuf #(
  parameter int PB_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lock,
  input  logic                        host_we,
  input  logic [$clog2(PB_BYTES)-1:0] host_addr,
  input  logic [7:0]                  host_wdata,
  output logic [7:0]                  host_rdata,
  input  logic                        eng_we,
  input  logic [$clog2(PB_BYTES)-1:0] eng_addr,
  input  logic [7:0]                  eng_wdata,
  output logic [7:0]                  eng_rdata,
  output logic [31:0]                 hdr_word0,
  output logic [31:0]                 hdr_word1
);
  logic [7:0] mem [PB_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PB_BYTES; i++) mem[i] <= 8'h00;
    end else if (eng_we) begin
      mem[eng_addr] <= eng_wdata;
    end else if (host_we && !lock) begin
      mem[host_addr] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_addr];
  assign eng_rdata  = mem[eng_addr];

  for (genvar g = 0; g < 4; g++) begin : g_hdr
    assign hdr_word0[8*g +: 8] = mem[g];
    assign hdr_word1[8*g +: 8] = mem[4+g];
  end
endmodule

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int AREA_BYTES = 128,
  parameter int PB_BYTES   = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic                          cmd_is_write,
  input  logic [15:0]                   cmd_len,
  input  logic [31:0]                   hdr_off,
  input  logic [31:0]                   hdr_len,
  output logic                          busy,
  output logic                          done,
  output logic [7:0]                    ret_code,
  output logic [15:0]                   out_len,
  output logic                          area_we,
  output logic [$clog2(AREA_BYTES)-1:0] area_addr,
  output logic [7:0]                    area_wdata,
  input  logic [7:0]                    area_rdata,
  output logic                          pb_we,
  output logic [$clog2(PB_BYTES)-1:0]   pb_addr,
  output logic [7:0]                    pb_wdata,
  input  logic [7:0]                    pb_rdata,
  output logic                          op_wr,
  output logic                          xfer_act,
  output logic [32:0]                   tgt_addr
);
  localparam int AAW = $clog2(AREA_BYTES);
  localparam int PAW = $clog2(PB_BYTES);
  localparam int CW  = $clog2(PB_BYTES + 1);

  lsa_state_e  st_q;
  logic        op_wr_q;
  logic [31:0] off_q;
  logic [31:0] len_q;
  logic [CW-1:0] idx_q, cnt_q;
  logic [7:0]  rc_q, ret_q;
  logic [15:0] olen_q, out_len_q;
  logic        done_q;

  logic [7:0]    chk_rc;
  logic [CW-1:0] chk_cnt;
  logic [15:0]   chk_olen;

  // Verdict for the latched command, used in ST_CHK.
  always_comb begin
    chk_rc   = RC_OK;
    chk_cnt  = '0;
    chk_olen = 16'd0;
    if (op_wr_q) begin
      if (len_q == 32'd0) begin
        chk_rc = RC_OK;
      end else if (!wr_in_bounds(off_q, len_q[15:0], AREA_BYTES, PB_BYTES)) begin
        chk_rc = RC_BAD_INPUT;
      end else begin
        chk_cnt = CW'(len_q - 32'(HDR_BYTES));
      end
    end else begin
      if (!rd_in_bounds(off_q, len_q, AREA_BYTES, PB_BYTES)) begin
        chk_rc = RC_BAD_INPUT;
      end else begin
        chk_cnt  = CW'(len_q);
        chk_olen = len_q[15:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_wr_q   <= 1'b0;
      off_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      rc_q      <= RC_OK;
      olen_q    <= '0;
      ret_q     <= RC_OK;
      out_len_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_wr_q <= cmd_is_write;
            off_q   <= hdr_off;
            len_q   <= cmd_is_write ? {16'd0, cmd_len} : hdr_len;
            idx_q   <= '0;
            st_q    <= ST_CHK;
          end
        end
        ST_CHK: begin
          rc_q   <= chk_rc;
          cnt_q  <= chk_cnt;
          olen_q <= chk_olen;
          st_q   <= (chk_cnt == '0) ? ST_FIN : ST_XFER;
        end
        ST_XFER: begin
          idx_q <= idx_q + CW'(1);
          if (idx_q == cnt_q - CW'(1)) st_q <= ST_FIN;
        end
        default: begin
          done_q    <= 1'b1;
          ret_q     <= rc_q;
          out_len_q <= olen_q;
          st_q      <= ST_IDLE;
        end
      endcase
    end
  end

  assign xfer_act   = (st_q == ST_XFER);
  assign tgt_addr   = {1'b0, off_q} + 33'(idx_q);
  assign area_addr  = tgt_addr[AAW-1:0];
  assign area_we    = xfer_act && op_wr_q;
  assign area_wdata = pb_rdata;
  assign pb_we      = xfer_act && !op_wr_q;
  assign pb_addr    = op_wr_q ? PAW'(idx_q + CW'(HDR_BYTES)) : PAW'(idx_q);
  assign pb_wdata   = area_rdata;

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign ret_code = ret_q;
  assign out_len  = out_len_q;
  assign op_wr    = op_wr_q;
endmodule

// File: rtl/lsa_engine.sv
module lsa_engine #(
  parameter int AREA_BYTES = 128,
  parameter int PB_BYTES   = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic                        cmd_is_write,
  input  logic [15:0]                 cmd_len,
  input  logic                        host_we,
  input  logic [$clog2(PB_BYTES)-1:0] host_addr,
  input  logic [7:0]                  host_wdata,
  output logic [7:0]                  host_rdata,
  output logic                        busy,
  output logic                        done,
  output logic [7:0]                  ret_code,
  output logic [15:0]                 out_len
);
  localparam int AAW = $clog2(AREA_BYTES);
  localparam int PAW = $clog2(PB_BYTES);

  logic [31:0]    hdr_off, hdr_len;
  logic           area_we;
  logic [AAW-1:0] area_addr;
  logic [7:0]     area_wdata, area_rdata;
  logic           pb_we;
  logic [PAW-1:0] pb_addr;
  logic [7:0]     pb_wdata, pb_rdata;
  logic           op_wr, xfer_act;
  logic [32:0]    tgt_addr;

  lsa_pbuf #(.PB_BYTES(PB_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .lock(busy),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .eng_we(pb_we), .eng_addr(pb_addr), .eng_wdata(pb_wdata),
    .eng_rdata(pb_rdata),
    .hdr_word0(hdr_off), .hdr_word1(hdr_len)
  );

  lsa_area #(.AREA_BYTES(AREA_BYTES)) u_area (
    .clk(clk), .rst_n(rst_n), .we(area_we), .addr(area_addr),
    .wdata(area_wdata), .rdata(area_rdata)
  );

  lsa_ctrl #(.AREA_BYTES(AREA_BYTES), .PB_BYTES(PB_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write), .cmd_len(cmd_len),
    .hdr_off(hdr_off), .hdr_len(hdr_len),
    .busy(busy), .done(done), .ret_code(ret_code), .out_len(out_len),
    .area_we(area_we), .area_addr(area_addr), .area_wdata(area_wdata),
    .area_rdata(area_rdata),
    .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
    .op_wr(op_wr), .xfer_act(xfer_act), .tgt_addr(tgt_addr)
  );
endmodule

// File: rtl/lsa_engine_chk.sv
module lsa_engine_chk #(
  parameter int AREA_BYTES = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic [7:0]  ret_code,
  input logic [15:0] out_len,
  input logic        area_we,
  input logic        op_wr,
  input logic        xfer_act,
  input logic [32:0] tgt_addr
);
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ret_code) && $stable(out_len)));

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R3
  reject_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ret_code == 8'h02) |-> (out_len == 16'd0));

  // R4
  write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_wr) |-> (out_len == 16'd0));

  // R6
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    area_we |-> (busy && op_wr));

  // R2
  store_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_act |-> (tgt_addr < 33'(AREA_BYTES)));
endmodule

bind lsa_engine lsa_engine_chk #(.AREA_BYTES(AREA_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .ret_code(ret_code), .out_len(out_len), .area_we(area_we), .op_wr(op_wr),
  .xfer_act(xfer_act), .tgt_addr(tgt_addr)
);

// File: tb/tb_lsa_engine.sv
`timescale 1ns/1ps
module tb_lsa_engine;
  localparam int AREA = 128;
  localparam int PB   = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_is_write = 1'b0;
  logic [15:0] cmd_len = '0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        busy, done;
  logic [7:0]  ret_code;
  logic [15:0] out_len;

  lsa_engine #(.AREA_BYTES(AREA), .PB_BYTES(PB)) dut (.*);

  int total = 0, bad = 0;
  int area_m[AREA];
  int pbuf_m[PB];
  bit finished = 0;

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(int a, int v);
    @(negedge clk);
    host_we = 1'b1; host_addr = 6'(a); host_wdata = 8'(v);
    pbuf_m[a] = v & 255;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic put32(int base, longint v);
    for (int b = 0; b < 4; b++) hwrite(base + b, int'((v >> (8*b)) & 255));
  endtask

  task automatic hread_chk(string req, int a);
    host_addr = 6'(a);
    #1;
    check(req, host_rdata, pbuf_m[a]);
  endtask

  // Issue a command and compare busy/done on every clock against the model.
  task automatic run(string req, bit wr, int plen, longint off, longint rlen, bit poke);
    int n = 0, rc = 0, ol = 0;
    if (wr) begin
      if (plen == 0) rc = 0;
      else if (plen < 8 || plen > PB || off + plen > AREA + 8) rc = 2;
      else n = plen - 8;
    end else begin
      if (off + rlen > AREA || rlen > PB) rc = 2;
      else begin n = int'(rlen); ol = int'(rlen); end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_write = wr; cmd_len = 16'(plen);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " busy"}, busy, 1);
    check({req, " done"}, done, 0);
    for (int k = 2; k <= n + 2; k++) begin
      @(negedge clk);
      if (busy !== 1'b1 || done !== 1'b0) check({req, " R7 busy window"}, {busy, done}, 2'b10);
      if (poke && k == 2) begin
        cmd_valid = 1'b1; cmd_is_write = !wr; cmd_len = 16'd0;
        host_we = 1'b1; host_addr = 6'(PB - 1); host_wdata = 8'hA5;
      end
      if (poke && k == 3) begin
        cmd_valid = 1'b0; host_we = 1'b0;
      end
    end
    @(negedge clk);
    check({req, " R7 done pulse"}, done, 1);
    check({req, " R7 busy low"}, busy, 0);
    check({req, " ret_code"}, ret_code, rc);
    check({req, " out_len"}, out_len, ol);
    if (rc == 0) begin
      for (int i = 0; i < n; i++) begin
        if (wr) area_m[int'(off) + i] = pbuf_m[8 + i];
        else    pbuf_m[i] = area_m[int'(off) + i];
      end
    end
    @(negedge clk);
    check({req, " R7 done single"}, done, 0);
    check({req, " R8 idle after"}, busy, 0);
    check({req, " R7 ret held"}, ret_code, rc);
  endtask

  task automatic do_read(string req, longint off, longint len);
    put32(0, off); put32(4, len);
    run(req, 1'b0, 8, off, len, 1'b0);
  endtask

  task automatic do_write(string req, longint off, int plen, int seed, bit poke);
    put32(0, off); put32(4, 32'hDEADBEEF);
    for (int i = 8; i < plen && i < PB; i++) hwrite(i, (seed + 7*i) & 255);
    run(req, 1'b1, plen, off, 0, poke);
  endtask

  task automatic verify_area(string req);
    for (int c = 0; c < AREA; c += PB) begin
      do_read({req, " readback"}, c, PB);
      for (int i = 0; i < PB; i++) hread_chk({req, " store byte"}, i);
    end
  endtask

  initial begin
    for (int i = 0; i < AREA; i++) area_m[i] = 0;
    for (int i = 0; i < PB; i++) pbuf_m[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ret_code", ret_code, 0);
    check("R1 out_len", out_len, 0);

    // R4 plain write, then R2 read back
    do_write("R4 write 16 at 5", 5, 24, 3, 1'b0);
    do_read("R2 read 16 at 5", 5, 16);
    for (int i = 0; i < 16; i++) hread_chk("R2 read data", i);
    // R2 zero-length and exact-edge reads
    do_read("R2 read len 0", 0, 0);
    do_write("R4 write at edge", AREA - 8, 16, 91, 1'b0);
    do_read("R2 read at edge", AREA - 8, 8);
    for (int i = 0; i < 8; i++) hread_chk("R2 edge data", i);
    // R3 rejects: payload must stay unchanged
    do_read("R3 read past edge", AREA - 7, 8);
    for (int i = 0; i < 8; i++) hread_chk("R3 payload kept", i);
    do_read("R3 read offset wrap", 64'hFFFF_FFFF, 2);
    for (int i = 0; i < 8; i++) hread_chk("R3 payload kept wrap", i);
    do_read("R3 read too long", 0, PB + 1);

    // R5 empty write
    do_write("R5 write empty", 10, 0, 0, 1'b0);
    // R6 rejects
    do_write("R6 write short", 20, 5, 0, 1'b0);
    do_write("R6 write past edge", AREA - 7, 16, 44, 1'b0);
    do_write("R6 write offset wrap", 64'hFFFF_FFF8, 16, 55, 1'b0);
    do_write("R6 write too long", 0, PB + 1, 66, 1'b0);
    // R4 header-only write
    do_write("R4 write header only", 30, 8, 0, 1'b0);
    verify_area("R6 store unchanged");

    // R8 strobe and host write while busy are ignored
    pbuf_m[PB-1] = pbuf_m[PB-1];
    do_write("R8 write with poke", 40, 12, 200, 1'b1);
    hread_chk("R8 host write ignored", PB - 1);
    verify_area("R8 store after poke");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule